// File: doc/BRIEF.md
# Low-Power Wake-Up Mode Controller

This block holds the operating mode of a system-basis-style companion device and decides when a sleeping microcontroller is woken. Software on the microcontroller asks for a new mode by writing a three-bit mode code through a single-cycle write strobe. A vector of one-cycle wake strobes arrives from the wake pins, the cyclic-sense engine, the force-wake timer, chip select and the bus receiver. The external reset pin is also watched: when it is held low past a glitch filter, it acts as a wake event.

Each low-power mode accepts its own set of wake sources. An accepted wake selects the next mode, sets a sticky per-source flag and pulses an interrupt. A reset-pin wake is the exception: it is silent toward software. The block also runs the start-up handshake. Reset mode holds the microcontroller reset low. Normal Request mode then waits for the software to confirm Normal mode, and if that confirmation does not come in time the block drops back to Reset. A watchdog-configuration input that reads as grounded bypasses Normal Request. All inputs and outputs are plain control and status pins, so there is no data stream and no back-pressure.

Top module: `wake_mode_ctrl`

## Requirements
- R1: Mode codes are Normal=0, Normal Request=1, Reset=2, Stop=3 and Sleep=4. While `rst_n` is low and on release, `mode` is 2, `mcu_rst_n` is 0, `flags` is 0 and `irq` is 0. Reset mode lasts RST_HOLD cycles and then moves to 1, or to 0 when `wd_gnd` is high.
- R2: In mode 0, a write of 3 or 4 moves to that mode on the next cycle. In mode 1, a write of 0 moves to mode 0. Every other write, in any mode, leaves the mode unchanged.
- R3: If Normal Request mode lasts NREQ_TMO cycles without a write of 0, the block enters mode 2 and `mcu_rst_n` goes low. The block then goes back through the R1 sequence.
- R4: In Stop mode, a strobe on any of the five `wake_evt` bits is accepted. The bits are: 0 wake pin, 1 cyclic sense, 2 force wake, 3 chip select, 4 bus. The next mode is 1, or 0 when `wd_gnd` is high.
- R5: In Sleep mode, wake bits 0, 1, 2 and 4 are accepted and the next mode is 2. Bit 3 (chip select) is ignored.
- R6: An accepted wake sets the flag bit with the same index as the source. That flag stays set, and `irq` is high for exactly the one cycle after acceptance. A set in the same cycle as a clear takes priority over the clear.
- R7: A `flag_rd` strobe clears all flags on the next cycle.
- R8: The reset-pin wake fires only when `rst_pin_n` is low for GLITCH_CYC consecutive cycles while in Stop mode. A shorter low pulse is ignored.
- R9: A reset-pin wake sets no flag and raises no `irq`. It is ignored in Sleep mode.
- R10: Wake strobes and reset-pin lows in modes 0, 1 and 2 change neither the flags nor `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_wr_data | input | 3 | Requested mode code |
| wd_gnd | input | 1 | Watchdog configuration reads as grounded (bypass Normal Request) |
| wake_evt | input | 5 | Wake strobes, bit order as in R4 |
| rst_pin_n | input | 1 | External reset pin level, active low |
| flag_rd | input | 1 | Flag read-and-clear strobe |
| mode | output | 3 | Current mode code |
| flags | output | 5 | Sticky wake-source flags |
| irq | output | 1 | One-cycle wake interrupt |
| mcu_rst_n | output | 1 | Reset to the microcontroller, active low |

## Verification
Each wake source is applied on its own in Stop mode and in Sleep mode. This tells the per-mode acceptance masks apart, and it tells the Normal Request target apart from the Reset target. Reset-pin lows are driven one cycle short of the filter length and then past it, in Stop, Sleep and Normal modes. This separates the filter threshold from the mode gating and shows that the event stays silent. Mode writes are tried with legal and illegal codes in every mode. A flag read is driven in the same cycle as a new wake to expose set-versus-clear priority. The Normal Request timeout is both allowed to expire and beaten by a confirming write, each with `wd_gnd` low and high.

// File: rtl/wmc_pkg.sv
package wmc_pkg;
  typedef enum logic [2:0] {
    MD_NORMAL = 3'd0,
    MD_NREQ   = 3'd1,
    MD_RESET  = 3'd2,
    MD_STOP   = 3'd3,
    MD_SLEEP  = 3'd4
  } mode_e;

  localparam int NSRC   = 5;
  localparam int SRC_CS = 3;
  localparam logic [NSRC-1:0] STOP_MASK  = '1;
  localparam logic [NSRC-1:0] SLEEP_MASK = ~(NSRC'(1) << SRC_CS);
endpackage

// File: rtl/wmc_rst_filter.sv
module wmc_rst_filter #(
  parameter int GLITCH_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic rpw_evt
);
  localparam int CW = $clog2(GLITCH_CYC + 1);
  localparam logic [CW-1:0] SAT  = CW'(GLITCH_CYC);
  localparam logic [CW-1:0] LAST = CW'(GLITCH_CYC - 1);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           low_cnt <= '0;
    else if (pin_n)       low_cnt <= '0;
    else if (low_cnt != SAT) low_cnt <= low_cnt + 1'b1;
  end

  // fires once, on the GLITCH_CYC-th consecutive low sample
  assign rpw_evt = !pin_n && (low_cnt == LAST);
endmodule

// File: rtl/wmc_wake_gate.sv
module wmc_wake_gate
  import wmc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  mode_e           mode,
  input  logic [NSRC-1:0] wake_evt,
  input  logic            flag_rd,
  output logic            acc,
  output logic [NSRC-1:0] flags,
  output logic            irq
);
  logic [NSRC-1:0] mask, hit;

  always_comb begin
    case (mode)
      MD_STOP:  mask = STOP_MASK;
      MD_SLEEP: mask = SLEEP_MASK;
      default:  mask = '0;
    endcase
  end

  assign hit = wake_evt & mask;
  assign acc = |hit;

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flags[i] <= 1'b0;
      else if (hit[i])  flags[i] <= 1'b1;
      else if (flag_rd) flags[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= acc;
  end
endmodule

// File: rtl/wmc_mode_fsm.sv
module wmc_mode_fsm
  import wmc_pkg::*;
#(
  parameter int NREQ_TMO = 20,
  parameter int RST_HOLD = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [2:0] mode_wr_data,
  input  logic       wd_gnd,
  input  logic       acc,
  input  logic       rpw_evt,
  output mode_e      mode,
  output logic       mcu_rst_n
);
  localparam int TMAX = (NREQ_TMO > RST_HOLD) ? NREQ_TMO : RST_HOLD;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] NREQ_LAST = TW'(NREQ_TMO - 1);
  localparam logic [TW-1:0] RST_LAST  = TW'(RST_HOLD - 1);

  logic [TW-1:0] tmr;
  mode_e         nxt, up_mode;

  assign up_mode = wd_gnd ? MD_NORMAL : MD_NREQ;

  always_comb begin
    nxt = mode;
    case (mode)
      MD_RESET:  if (tmr == RST_LAST) nxt = up_mode;
      MD_NREQ: begin
        if (mode_wr && mode_wr_data == MD_NORMAL) nxt = MD_NORMAL;
        else if (tmr == NREQ_LAST)                nxt = MD_RESET;
      end
      MD_NORMAL: begin
        if (mode_wr && mode_wr_data == MD_STOP)       nxt = MD_STOP;
        else if (mode_wr && mode_wr_data == MD_SLEEP) nxt = MD_SLEEP;
      end
      MD_STOP:   if (acc || rpw_evt) nxt = up_mode;
      MD_SLEEP:  if (acc) nxt = MD_RESET;
      default:   nxt = MD_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= MD_RESET;
      tmr       <= '0;
      mcu_rst_n <= 1'b0;
    end else begin
      mode      <= nxt;
      mcu_rst_n <= (nxt != MD_RESET);
      if (nxt != mode || !(mode == MD_NREQ || mode == MD_RESET)) tmr <= '0;
      else                                                      tmr <= tmr + 1'b1;
    end
  end
endmodule

// File: rtl/wake_mode_ctrl.sv
module wake_mode_ctrl
  import wmc_pkg::*;
#(
  parameter int GLITCH_CYC = 4,
  parameter int NREQ_TMO   = 20,
  parameter int RST_HOLD   = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [2:0] mode_wr_data,
  input  logic       wd_gnd,
  input  logic [4:0] wake_evt,
  input  logic       rst_pin_n,
  input  logic       flag_rd,
  output logic [2:0] mode,
  output logic [4:0] flags,
  output logic       irq,
  output logic       mcu_rst_n
);
  logic  acc, rpw_evt;
  mode_e cur_mode;

  wmc_rst_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filt (
    .clk(clk), .rst_n(rst_n), .pin_n(rst_pin_n), .rpw_evt(rpw_evt)
  );

  wmc_wake_gate u_gate (
    .clk(clk), .rst_n(rst_n), .mode(cur_mode), .wake_evt(wake_evt),
    .flag_rd(flag_rd), .acc(acc), .flags(flags), .irq(irq)
  );

  wmc_mode_fsm #(.NREQ_TMO(NREQ_TMO), .RST_HOLD(RST_HOLD)) u_fsm (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wr_data(mode_wr_data),
    .wd_gnd(wd_gnd), .acc(acc), .rpw_evt(rpw_evt), .mode(cur_mode),
    .mcu_rst_n(mcu_rst_n)
  );

  assign mode = cur_mode;
endmodule

// File: rtl/wake_mode_ctrl_chk.sv
module wake_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_wr,
  input logic [2:0] mode_wr_data,
  input logic       wd_gnd,
  input logic [4:0] wake_evt,
  input logic       flag_rd,
  input logic [2:0] mode,
  input logic [4:0] flags,
  input logic       irq,
  input logic       mcu_rst_n,
  input logic       acc,
  input logic       rpw_evt
);
  p_legal_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mode <= 3'd4);
  p_nreq_confirm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && mode_wr && mode_wr_data == 3'd0) |=> mode == 3'd0);
  p_stop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && !acc && !rpw_evt) |=> mode == 3'd3);
  p_rst_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mcu_rst_n) |-> (mode == 3'd0 || mode == 3'd1));
  p_stop_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && acc && wd_gnd) |=> mode == 3'd0);
  p_sleep_cs_ign_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && (wake_evt & 5'b10111) == 5'b0) |=> mode == 3'd4);
  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  p_irq_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $countones(flags) > 0);
  p_rd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && wake_evt == 5'b0) |=> flags == 5'b0);
  p_rpw_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && rpw_evt && !acc) |=> !irq);
  p_quiet_modes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode <= 3'd2) |=> !irq);
endmodule

bind wake_mode_ctrl wake_mode_ctrl_chk u_chk (.*);

// File: tb/wake_mode_ctrl_bench.sv
module wake_mode_ctrl_bench;
  localparam int G = 4, T = 20, H = 5;

  logic clk = 0, rst_n = 0, mode_wr = 0, wd_gnd = 0, rst_pin_n = 1, flag_rd = 0;
  logic [2:0] mode_wr_data = 0;
  logic [4:0] wake_evt = 0;
  logic [2:0] mode;
  logic [4:0] flags;
  logic irq, mcu_rst_n;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";

  // reference model state
  int m_mode = 2, m_tmr = 0, m_low = 0, m_flags = 0, m_irq = 0;

  always #4 clk = ~clk;

  wake_mode_ctrl #(.GLITCH_CYC(G), .NREQ_TMO(T), .RST_HOLD(H)) u_wake_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wr_data(mode_wr_data),
    .wd_gnd(wd_gnd), .wake_evt(wake_evt), .rst_pin_n(rst_pin_n),
    .flag_rd(flag_rd), .mode(mode), .flags(flags), .irq(irq),
    .mcu_rst_n(mcu_rst_n)
  );

  always @(posedge clk) begin
    int hit, nm, up, rpw;
    if (!rst_n) begin
      m_mode = 2; m_tmr = 0; m_low = 0; m_flags = 0; m_irq = 0;
    end else begin
      hit = (m_mode == 3) ? int'(wake_evt) : (m_mode == 4) ? (int'(wake_evt) & 23) : 0;
      m_low = rst_pin_n ? 0 : m_low + 1;
      rpw = (m_low == G);
      up = wd_gnd ? 0 : 1;
      nm = m_mode;
      case (m_mode)
        2: if (m_tmr == H - 1) nm = up;
        1: if (mode_wr && mode_wr_data == 0) nm = 0; else if (m_tmr == T - 1) nm = 2;
        0: if (mode_wr && (mode_wr_data == 3 || mode_wr_data == 4)) nm = mode_wr_data;
        3: if (hit != 0 || rpw) nm = up;
        4: if (hit != 0) nm = 2;
        default: nm = 2;
      endcase
      m_tmr = (nm != m_mode) ? 0 : m_tmr + 1;
      m_mode = nm;
      m_flags = (flag_rd ? 0 : m_flags) | hit;
      m_irq = (hit != 0);
    end
  end

  task automatic cmp(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d (cycle %0d)", cur_req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    cmp("mode", int'(mode), m_mode);
    cmp("flags", int'(flags), m_flags);
    cmp("irq", int'(irq), m_irq);
    cmp("mcu_rst_n", int'(mcu_rst_n), (m_mode == 2) ? 0 : 1);
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int code);
    @(negedge clk); mode_wr = 1; mode_wr_data = 3'(code);
    @(negedge clk); mode_wr = 0;
  endtask

  task automatic wake(int vec, bit rd);
    @(negedge clk); wake_evt = 5'(vec); flag_rd = rd;
    @(negedge clk); wake_evt = 0; flag_rd = 0;
  endtask

  task automatic rd_flags();
    @(negedge clk); flag_rd = 1;
    @(negedge clk); flag_rd = 0;
  endtask

  task automatic pin_low(int n);
    @(negedge clk); rst_pin_n = 0;
    repeat (n) @(negedge clk);
    rst_pin_n = 1;
  endtask

  initial begin
    cur_req = "R1"; idle(3); rst_n = 1; idle(H + 3);           // Reset -> NREQ
    cur_req = "R3"; idle(T + H + 4);                           // timeout -> Reset -> NREQ
    cur_req = "R2"; wr(0); wr(5); wr(1); wr(2);                // confirm, then illegal writes
    cur_req = "R10"; wake(31, 0); pin_low(G + 2); idle(2);     // quiet in Normal
    cur_req = "R2"; wr(3); wr(0); wr(4); idle(2);              // Stop, writes ignored
    cur_req = "R8"; pin_low(G - 1); idle(3);                   // glitch ignored
    cur_req = "R9"; pin_low(G + 1); idle(3);                   // silent wake -> NREQ
    cur_req = "R2"; wr(0);
    cur_req = "R4"; wr(3); wake(8, 0); idle(2);                // CS in Stop -> NREQ
    cur_req = "R7"; rd_flags(); idle(2);
    cur_req = "R2"; wr(0);
    cur_req = "R4"; wd_gnd = 1; wr(3); wake(16, 0); idle(2);   // bus wake -> Normal
    cur_req = "R5"; wr(4); wake(8, 0); idle(2);                // CS ignored in Sleep
    cur_req = "R9"; pin_low(G + 2); idle(2);                   // pin ignored in Sleep
    cur_req = "R5"; wake(2, 0); idle(H + 3);                   // -> Reset -> Normal
    cur_req = "R6"; wr(4); wake(1, 1); idle(H + 3);            // set beats clear
    cur_req = "R7"; rd_flags(); idle(2);
    cur_req = "R3"; wd_gnd = 0; wr(4); wake(4, 0); idle(H + 4); // Sleep -> Reset -> NREQ
    cur_req = "R6"; wake(1, 0); idle(T + H + 4);
    cur_req = "R1"; rst_n = 0; idle(2); rst_n = 1; idle(H + 2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule